// File: doc/BRIEF.md
# Dual-Port Memory with Mailbox Interrupts

This block is a word-addressed memory shared by two independent ports, called left and right. Both sit on one clock. Each port has its own active-low chip select, output enable and write strobe, plus its own address, write data and registered read data. Either port can read or write any word at any time.

The two highest words of the array also serve as mailboxes. The word at all-ones minus one belongs to the left port. A write to it by the right port pulls the left port's active-low interrupt output low. The left port dismisses that interrupt by selecting the word with output enable asserted. The all-ones word belongs to the right port and works the same way in the other direction: a write by the left port raises the right interrupt, and a read by the right port dismisses it. The mailbox words hold ordinary data, so the sender can place a message there and the receiver reads it while it clears the interrupt.

A parameter turns the mailbox feature off. The top two words then behave as plain storage. The default address width gives 1K words; an address width of 16 gives a 64K-word array.

Top module: `dpmb_mailbox`

## Requirements
- R1: After reset, both `l_irq_n` and `r_irq_n` are high, and both read data outputs are zero.
- R2: A port writes when `cs_n`=0 and `we_n`=0. It reads when `cs_n`=0, `we_n`=1 and `oe_n`=0, and the word appears on its `rdata` after the next rising clock edge. In every other cycle `rdata` keeps its value.
- R3: A port with `cs_n`=1 performs no access. It stores nothing, its `rdata` keeps its value, and it neither sets nor clears any interrupt.
- R4: A right-port write to address all-ones minus one (0x3FE at the default width) drives `l_irq_n` low after that clock edge.
- R5: A left-port write to address all-ones (0x3FF at the default width) drives `r_irq_n` low after that clock edge.
- R6: The left interrupt clears when the left port has `cs_n`=0 and `oe_n`=0 at address all-ones minus one, whatever `we_n` is. With `oe_n`=1 the access does not clear it.
- R7: The right interrupt clears only on a right-port read (R2 encoding) of address all-ones. A right-port write to that word neither sets nor clears it.
- R8: Both mailbox words store data and return it like any other word.
- R9: If a set and a clear reach the same interrupt in the same cycle, the interrupt ends up set.
- R10: With `MBOX_EN`=0, both interrupt outputs stay high, and the top two words act as plain storage.
- R11: If both ports write the same address in the same cycle, the right port's data is stored. A read of a word that the other port writes in the same cycle returns the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| l_cs_n | input | 1 | Left chip select, active low |
| l_oe_n | input | 1 | Left output enable, active low |
| l_we_n | input | 1 | Left write strobe, active low (high means read) |
| l_addr | input | AW | Left word address |
| l_wdata | input | DW | Left write data |
| l_rdata | output | DW | Left registered read data |
| l_irq_n | output | 1 | Left mailbox interrupt, active low |
| r_cs_n | input | 1 | Right chip select, active low |
| r_oe_n | input | 1 | Right output enable, active low |
| r_we_n | input | 1 | Right write strobe, active low (high means read) |
| r_addr | input | AW | Right word address |
| r_wdata | input | DW | Right write data |
| r_rdata | output | DW | Right registered read data |
| r_irq_n | output | 1 | Right mailbox interrupt, active low |

## Verification
The setting and the clearing of one interrupt can land on the same clock edge. For the left interrupt, this happens when the right port writes 0x3FE while the left port selects 0x3FE with output enable low. For the right interrupt, the left port writes 0x3FF while the right port reads it. The bench drives both ports in the same cycle and expects the interrupt low afterwards. The reading port must see the word as it was before the write, and a following solo clear must release the interrupt. The same pairing of ports checks that writes to one address from both sides resolve in the right port's favour.

// File: rtl/dpmb_pkg.sv
package dpmb_pkg;

  // Strobes decoded from one port's control pins.
  typedef struct packed {
    logic wr;      // store wdata at addr
    logic rd;      // load rdata from addr
    logic sel_oe;  // selected with output enable asserted
  } dpmb_strb_t;

  function automatic dpmb_strb_t dpmb_decode(input logic cs_n,
                                             input logic oe_n,
                                             input logic we_n);
    dpmb_strb_t s;
    s.wr     = ~cs_n & ~we_n;
    s.rd     = ~cs_n &  we_n & ~oe_n;
    s.sel_oe = ~cs_n & ~oe_n;
    return s;
  endfunction

endpackage

// File: rtl/dpmb_port_dec.sv
module dpmb_port_dec
  import dpmb_pkg::*;
#(
  parameter int          AW          = 10,
  parameter logic [AW-1:0] OWN_MB    = '1,
  parameter logic [AW-1:0] PEER_MB   = '1,
  parameter bit          CLR_ANY_DIR = 1'b0
) (
  input  logic          cs_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  output logic          wr,
  output logic          rd,
  output logic          peer_set,
  output logic          own_clr
);

  dpmb_strb_t strb;
  logic       own_hit;
  logic       peer_hit;

  always_comb begin
    strb     = dpmb_decode(cs_n, oe_n, we_n);
    own_hit  = (addr == OWN_MB);
    peer_hit = (addr == PEER_MB);
    wr       = strb.wr;
    rd       = strb.rd;
    peer_set = strb.wr & peer_hit;
  end

  generate
    if (CLR_ANY_DIR) begin : g_clr_any
      assign own_clr = strb.sel_oe & own_hit;
    end else begin : g_clr_read
      assign own_clr = strb.rd & own_hit;
    end
  endgenerate

endmodule

// File: rtl/dpmb_flag.sv
module dpmb_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq_n
);

  logic flag_q;
  logic flag_d;

  // set dominates clear
  always_comb begin
    flag_d = flag_q;
    if (clr) flag_d = 1'b0;
    if (set) flag_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign irq_n = ~flag_q;

endmodule

// File: rtl/dpmb_ram.sv
module dpmb_ram #(
  parameter int AW = 10,
  parameter int DW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          a_wr,
  input  logic          a_rd,
  input  logic [AW-1:0] a_addr,
  input  logic [DW-1:0] a_wdata,
  output logic [DW-1:0] a_rdata,
  input  logic          b_wr,
  input  logic          b_rd,
  input  logic [AW-1:0] b_addr,
  input  logic [DW-1:0] b_wdata,
  output logic [DW-1:0] b_rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] a_rdata_q, a_rdata_d;
  logic [DW-1:0] b_rdata_q, b_rdata_d;

  // Array has no reset; the b side is written last and wins a tie.
  always_ff @(posedge clk) begin
    if (a_wr) mem[a_addr] <= a_wdata;
    if (b_wr) mem[b_addr] <= b_wdata;
  end

  always_comb begin
    a_rdata_d = a_rdata_q;
    b_rdata_d = b_rdata_q;
    if (a_rd) a_rdata_d = mem[a_addr];
    if (b_rd) b_rdata_d = mem[b_addr];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_rdata_q <= '0;
      b_rdata_q <= '0;
    end else begin
      a_rdata_q <= a_rdata_d;
      b_rdata_q <= b_rdata_d;
    end
  end

  assign a_rdata = a_rdata_q;
  assign b_rdata = b_rdata_q;

endmodule

// File: rtl/dpmb_mailbox.sv
module dpmb_mailbox #(
  parameter int AW      = 10,
  parameter int DW      = 9,
  parameter bit MBOX_EN = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_cs_n,
  input  logic          l_oe_n,
  input  logic          l_we_n,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_wdata,
  output logic [DW-1:0] l_rdata,
  output logic          l_irq_n,
  input  logic          r_cs_n,
  input  logic          r_oe_n,
  input  logic          r_we_n,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_wdata,
  output logic [DW-1:0] r_rdata,
  output logic          r_irq_n
);

  localparam logic [AW-1:0] MB_RIGHT = '1;
  localparam logic [AW-1:0] MB_LEFT  = MB_RIGHT - 1'b1;
  localparam int            NPORT    = 2;

  // reset: asynchronous assert, synchronous release
  logic rst_s1, rst_sn;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_sn <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_sn <= rst_s1;
    end
  end

  logic          cs_n_v [NPORT];
  logic          oe_n_v [NPORT];
  logic          we_n_v [NPORT];
  logic [AW-1:0] addr_v [NPORT];
  logic          wr_v   [NPORT];
  logic          rd_v   [NPORT];
  logic          pset_v [NPORT];
  logic          oclr_v [NPORT];
  logic          irq_v  [NPORT];

  assign cs_n_v[0] = l_cs_n;  assign cs_n_v[1] = r_cs_n;
  assign oe_n_v[0] = l_oe_n;  assign oe_n_v[1] = r_oe_n;
  assign we_n_v[0] = l_we_n;  assign we_n_v[1] = r_we_n;
  assign addr_v[0] = l_addr;  assign addr_v[1] = r_addr;

  genvar p;
  generate
    for (p = 0; p < NPORT; p++) begin : g_port
      localparam logic [AW-1:0] OWN  = (p == 0) ? MB_LEFT  : MB_RIGHT;
      localparam logic [AW-1:0] PEER = (p == 0) ? MB_RIGHT : MB_LEFT;
      localparam bit            ANY  = (p == 0);

      dpmb_port_dec #(
        .AW(AW), .OWN_MB(OWN), .PEER_MB(PEER), .CLR_ANY_DIR(ANY)
      ) u_dec (
        .cs_n    (cs_n_v[p]),
        .oe_n    (oe_n_v[p]),
        .we_n    (we_n_v[p]),
        .addr    (addr_v[p]),
        .wr      (wr_v[p]),
        .rd      (rd_v[p]),
        .peer_set(pset_v[p]),
        .own_clr (oclr_v[p])
      );

      // flag p is set by the other port and cleared by its own port
      dpmb_flag u_flag (
        .clk  (clk),
        .rst_n(rst_sn),
        .set  (MBOX_EN & pset_v[NPORT-1-p]),
        .clr  (MBOX_EN & oclr_v[p]),
        .irq_n(irq_v[p])
      );
    end
  endgenerate

  assign l_irq_n = irq_v[0];
  assign r_irq_n = irq_v[1];

  dpmb_ram #(.AW(AW), .DW(DW)) u_ram (
    .clk    (clk),
    .rst_n  (rst_sn),
    .a_wr   (wr_v[0]),
    .a_rd   (rd_v[0]),
    .a_addr (l_addr),
    .a_wdata(l_wdata),
    .a_rdata(l_rdata),
    .b_wr   (wr_v[1]),
    .b_rd   (rd_v[1]),
    .b_addr (r_addr),
    .b_wdata(r_wdata),
    .b_rdata(r_rdata)
  );

endmodule

// File: rtl/dpmb_mailbox_chk.sv
module dpmb_mailbox_chk #(
  parameter int AW      = 10,
  parameter int DW      = 9,
  parameter bit MBOX_EN = 1'b1
) (
  input logic          clk,
  input logic          rst_sn,
  input logic          l_cs_n,
  input logic          l_oe_n,
  input logic          l_we_n,
  input logic [AW-1:0] l_addr,
  input logic [DW-1:0] l_rdata,
  input logic          l_irq_n,
  input logic          r_cs_n,
  input logic          r_oe_n,
  input logic          r_we_n,
  input logic [AW-1:0] r_addr,
  input logic [DW-1:0] r_rdata,
  input logic          r_irq_n
);

  localparam logic [AW-1:0] MBR = '1;
  localparam logic [AW-1:0] MBL = MBR - 1'b1;

  logic r_wr_mbl, l_wr_mbr, l_clr, r_clr, l_read, r_read;
  assign r_wr_mbl = !r_cs_n && !r_we_n && (r_addr == MBL);
  assign l_wr_mbr = !l_cs_n && !l_we_n && (l_addr == MBR);
  assign l_clr    = !l_cs_n && !l_oe_n && (l_addr == MBL);
  assign r_read   = !r_cs_n && r_we_n && !r_oe_n;
  assign l_read   = !l_cs_n && l_we_n && !l_oe_n;
  assign r_clr    = r_read && (r_addr == MBR);

  assert_lirq_set_R4: assert property (@(posedge clk) disable iff (!rst_sn)
    (MBOX_EN && r_wr_mbl) |=> !l_irq_n);

  assert_rirq_set_R5: assert property (@(posedge clk) disable iff (!rst_sn)
    (MBOX_EN && l_wr_mbr) |=> !r_irq_n);

  assert_lirq_clr_R6: assert property (@(posedge clk) disable iff (!rst_sn)
    (MBOX_EN && l_clr && !r_wr_mbl) |=> l_irq_n);

  assert_rirq_clr_R7: assert property (@(posedge clk) disable iff (!rst_sn)
    (MBOX_EN && r_clr && !l_wr_mbr) |=> r_irq_n);

  assert_lirq_hold_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    (!l_clr && !r_wr_mbl) |=> $stable(l_irq_n));

  assert_rirq_hold_R3: assert property (@(posedge clk) disable iff (!rst_sn)
    (!r_clr && !l_wr_mbr) |=> $stable(r_irq_n));

  assert_lrd_hold_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    !l_read |=> $stable(l_rdata));

  assert_rrd_hold_R2: assert property (@(posedge clk) disable iff (!rst_sn)
    !r_read |=> $stable(r_rdata));

  assert_noirq_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    !MBOX_EN |-> (l_irq_n && r_irq_n));

endmodule

bind dpmb_mailbox dpmb_mailbox_chk #(.AW(AW), .DW(DW), .MBOX_EN(MBOX_EN)) u_chk (
  .clk    (clk),
  .rst_sn (rst_sn),
  .l_cs_n (l_cs_n),
  .l_oe_n (l_oe_n),
  .l_we_n (l_we_n),
  .l_addr (l_addr),
  .l_rdata(l_rdata),
  .l_irq_n(l_irq_n),
  .r_cs_n (r_cs_n),
  .r_oe_n (r_oe_n),
  .r_we_n (r_we_n),
  .r_addr (r_addr),
  .r_rdata(r_rdata),
  .r_irq_n(r_irq_n)
);

// File: tb/dpmb_mailbox_bench.sv
`timescale 1ns/1ps
module dpmb_mailbox_bench;

  localparam int AW = 10;
  localparam int DW = 9;
  localparam logic [AW-1:0] MBR = 10'h3FF;
  localparam logic [AW-1:0] MBL = 10'h3FE;

  logic clk = 1'b0;
  logic rst_n;
  logic l_cs_n, l_oe_n, l_we_n, r_cs_n, r_oe_n, r_we_n;
  logic [AW-1:0] l_addr, r_addr;
  logic [DW-1:0] l_wdata, r_wdata;
  logic [DW-1:0] l_rdata, r_rdata, p_l_rdata, p_r_rdata;
  logic l_irq_n, r_irq_n, p_l_irq_n, p_r_irq_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  dpmb_mailbox #(.AW(AW), .DW(DW), .MBOX_EN(1'b1)) u_dpmb_mailbox (
    .clk(clk), .rst_n(rst_n),
    .l_cs_n(l_cs_n), .l_oe_n(l_oe_n), .l_we_n(l_we_n), .l_addr(l_addr),
    .l_wdata(l_wdata), .l_rdata(l_rdata), .l_irq_n(l_irq_n),
    .r_cs_n(r_cs_n), .r_oe_n(r_oe_n), .r_we_n(r_we_n), .r_addr(r_addr),
    .r_wdata(r_wdata), .r_rdata(r_rdata), .r_irq_n(r_irq_n));

  dpmb_mailbox #(.AW(AW), .DW(DW), .MBOX_EN(1'b0)) u_dpmb_mailbox_plain (
    .clk(clk), .rst_n(rst_n),
    .l_cs_n(l_cs_n), .l_oe_n(l_oe_n), .l_we_n(l_we_n), .l_addr(l_addr),
    .l_wdata(l_wdata), .l_rdata(p_l_rdata), .l_irq_n(p_l_irq_n),
    .r_cs_n(r_cs_n), .r_oe_n(r_oe_n), .r_we_n(r_we_n), .r_addr(r_addr),
    .r_wdata(r_wdata), .r_rdata(p_r_rdata), .r_irq_n(p_r_irq_n));

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    l_cs_n = 1; l_oe_n = 1; l_we_n = 1; l_addr = '0; l_wdata = '0;
    r_cs_n = 1; r_oe_n = 1; r_we_n = 1; r_addr = '0; r_wdata = '0;
  endtask

  task automatic lset(input logic cs, oe, we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    l_cs_n = cs; l_oe_n = oe; l_we_n = we; l_addr = a; l_wdata = d;
  endtask

  task automatic rset(input logic cs, oe, we, input logic [AW-1:0] a, input logic [DW-1:0] d);
    r_cs_n = cs; r_oe_n = oe; r_we_n = we; r_addr = a; r_wdata = d;
  endtask

  // one clock edge, then sample at the following falling edge
  task automatic step();
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    chk("R1 l_irq_n", l_irq_n, 1);
    chk("R1 r_irq_n", r_irq_n, 1);
    chk("R1 l_rdata", l_rdata, 0);
    chk("R1 r_rdata", r_rdata, 0);
  endtask

  task automatic t_basic_rw();
    lset(0, 1, 0, 10'd5, 9'h1A5); rset(0, 1, 0, 10'd6, 9'h0C3); step();
    lset(0, 0, 1, 10'd6, 0);      rset(0, 0, 1, 10'd5, 0);      step();
    chk("R2 l_rdata", l_rdata, 9'h0C3);
    chk("R2 r_rdata", r_rdata, 9'h1A5);
    step();
    chk("R2 l_rdata hold", l_rdata, 9'h0C3);
    chk("R2 irq quiet", {l_irq_n, r_irq_n}, 2'b11);
  endtask

  task automatic t_deselect();
    lset(1, 0, 1, 10'd5, 0); rset(1, 1, 0, MBL, 9'h077); step();
    chk("R3 l_rdata hold", l_rdata, 9'h0C3);
    chk("R3 no irq", l_irq_n, 1);
    lset(1, 1, 0, 10'd5, 9'h000); step();
    lset(0, 0, 1, 10'd5, 0); step();
    chk("R3 no write", l_rdata, 9'h1A5);
  endtask

  task automatic t_left_irq();
    rset(0, 1, 0, MBL, 9'h155); step();
    chk("R4 l_irq_n set", l_irq_n, 0);
    chk("R10 plain l_irq_n", p_l_irq_n, 1);
    lset(0, 1, 1, MBL, 0); step();
    chk("R6 oe high keeps", l_irq_n, 0);
    lset(0, 0, 1, MBL, 0); step();
    chk("R8 l mailbox data", l_rdata, 9'h155);
    chk("R6 read clears", l_irq_n, 1);
    rset(0, 1, 0, MBL, 9'h0AA); step();
    chk("R4 set again", l_irq_n, 0);
    lset(0, 0, 0, MBL, 9'h0AB); step();
    chk("R6 write w/ oe clears", l_irq_n, 1);
    lset(0, 0, 1, MBL, 0); step();
    chk("R8 l mailbox rewritten", l_rdata, 9'h0AB);
  endtask

  task automatic t_right_irq();
    lset(0, 1, 0, MBR, 9'h123); step();
    chk("R5 r_irq_n set", r_irq_n, 0);
    chk("R5 l_irq_n untouched", l_irq_n, 1);
    chk("R10 plain r_irq_n", p_r_irq_n, 1);
    rset(0, 0, 0, MBR, 9'h0F0); step();
    chk("R7 own write keeps", r_irq_n, 0);
    rset(0, 1, 1, MBR, 0); step();
    chk("R7 oe high keeps", r_irq_n, 0);
    rset(0, 0, 1, MBR, 0); step();
    chk("R8 r mailbox data", r_rdata, 9'h0F0);
    chk("R7 read clears", r_irq_n, 1);
    rset(0, 1, 0, MBR, 9'h0F1); step();
    chk("R7 own write no set", r_irq_n, 1);
  endtask

  task automatic t_collide();
    rset(0, 1, 0, MBL, 9'h011); lset(0, 0, 1, MBL, 0); step();
    chk("R9 l set wins", l_irq_n, 0);
    chk("R11 l old data", l_rdata, 9'h0AB);
    lset(0, 0, 1, MBL, 0); step();
    chk("R9 l later clear", l_irq_n, 1);
    chk("R8 l new data", l_rdata, 9'h011);
    lset(0, 1, 0, MBR, 9'h022); rset(0, 0, 1, MBR, 0); step();
    chk("R9 r set wins", r_irq_n, 0);
    chk("R11 r old data", r_rdata, 9'h0F1);
    rset(0, 0, 1, MBR, 0); step();
    chk("R9 r later clear", r_irq_n, 1);
  endtask

  task automatic t_same_addr();
    lset(0, 1, 0, 10'd9, 9'h001); rset(0, 1, 0, 10'd9, 9'h1FE); step();
    lset(0, 0, 1, 10'd9, 0); step();
    chk("R11 right wins", l_rdata, 9'h1FE);
  endtask

  task automatic t_plain();
    lset(0, 0, 1, MBL, 0); rset(0, 0, 1, MBR, 0); step();
    chk("R10 plain MBL data", p_l_rdata, 9'h011);
    chk("R10 plain MBR data", p_r_rdata, 9'h022);
    chk("R10 plain irqs", {p_l_irq_n, p_r_irq_n}, 2'b11);
  endtask

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_basic_rw();
    t_deselect();
    t_left_irq();
    t_right_irq();
    t_collide();
    t_same_addr();
    t_plain();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule